// File: doc/BRIEF.md
# MDIO management master

This block lets a host processor reach the management registers of Ethernet PHYs over the two-wire Clause 22 management bus. The host uses a small word-addressed register port. It first stores a PHY address and a register number. Writing a 16-bit value to the write-data register immediately launches a write frame. Taking the read-command bit from 0 to 1 launches a read frame. The sixteen returned bits then land in the read-result register.

The host polls an indication register, which carries two flags. The frame-active flag stays high for the whole frame. The result-pending flag is raised when a read starts and stays high until the read data has been captured. A setup register holds the MDC divider and a soft-reset bit. The soft-reset bit aborts any frame and keeps the engine idle. While a frame is active, host writes to the address, write-data and command registers are dropped. The MDIO line is driven through a data/output-enable pair, so a pull-up and a tri-state buffer can sit outside the block.

Top module: `mdio_master`

## Requirements
- R1: The address register (offset 1) holds the PHY address in bits [12:8] and the register number in bits [4:0], and reads back in that layout with the other bits zero.
- R2: A write to the write-data register (offset 2) stores bits [15:0] and at once starts a frame. The frame is 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits, all sent MSB first.
- R3: A read frame (opcode 10) starts only when bit 0 of the command register (offset 3) is written as 1 while it currently holds 0. Writing 1 while it already holds 1 starts nothing.
- R4: Bit 0 of the indication register (offset 5) reads 1 from the cycle after a frame starts until the MDC fall that ends the 64th bit.
- R5: Bit 1 of the indication register is set when a read starts. It is cleared in the same cycle that the sampled data enters the read-result register.
- R6: The read-result register (offset 4) returns the last read value in bits [15:0]. With no PHY answering, the pulled-up line yields 16'hFFFF.
- R7: Setting bit 31 of the setup register (offset 0) aborts any frame. While the bit stays set, the frame-active flag and the result-pending flag both read 0, MDC stays low and MDIO is released.
- R8: With d = setup bits [7:0], raised to 1 when written as 0, MDC has a period of 2·(d+1) clocks during a frame and rests low between frames.
- R9: On reads the master releases MDIO from the first turnaround bit onward and samples data on rising MDC edges. On writes it drives every bit. Between frames MDIO is released.
- R10: Host writes to the address, write-data and command registers are ignored while a frame is active or soft reset is set. This is judged on the state before the write's clock edge.
- R11: After reset, the divider reads 2 and every other register reads 0; MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears one cycle later |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Two events can meet in one clock edge: the end of a frame and a host write that would launch the next frame. The bench provokes this by presenting a write-data store in the very cycle the last MDC fall happens, and holding the strobe for one more cycle. The first attempt must be dropped, since the frame was still active before the edge. The second attempt must start a fresh frame. A behavioural model in the bench replays both decisions and compares MDC, MDIO and the register contents on every clock. The same model also meets a soft reset landing mid-read, and a command rewrite of 1 that must not relaunch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W      = 32;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int FLD_W      = 5;
  localparam int TA_POS     = 46;   // first turnaround bit index
  localparam int DATA_POS   = 48;   // first data bit index
  localparam int SRST_BIT   = 31;
  localparam int PHY_LSB    = 8;
  localparam int BUSY_BIT   = 0;
  localparam int NV_BIT     = 1;
  localparam int RDCMD_BIT  = 0;

  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_ADDR = 3'd1,
    RA_CTRL = 3'd2,
    RA_CMD  = 3'd3,
    RA_STAT = 3'd4,
    RA_IND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             tick;

  always_comb begin
    div_eff   = (div == '0) ? DIV_W'(1) : div;
    tick      = run && (cnt >= div_eff);
    rise_tick = tick && !mdc;
    fall_tick = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 srst,
  input  logic                 start_wr,
  input  logic                 start_rd,
  input  logic [FLD_W-1:0]     phy,
  input  logic [FLD_W-1:0]     regn,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 is_rd,
  output logic                 nv,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sr;
  logic [FRAME_BITS-1:0] frame_ld;
  logic [IDX_W-1:0]      idx;
  logic [DATA_BITS-1:0]  rsh;

  always_comb begin
    frame_ld = {{PRE_BITS{1'b1}}, 2'b01,
                start_rd ? 2'b10 : 2'b01,
                phy, regn,
                start_rd ? 2'b11 : 2'b10,
                start_rd ? {DATA_BITS{1'b1}} : wdata};
  end

  assign mdio_o = sr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      nv      <= 1'b0;
      idx     <= '0;
      sr      <= '1;
      mdio_oe <= 1'b0;
      rsh     <= '0;
      rd_data <= '0;
    end else if (srst) begin
      busy    <= 1'b0;
      nv      <= 1'b0;
      idx     <= '0;
      sr      <= '1;
      mdio_oe <= 1'b0;
    end else if (start_wr || start_rd) begin
      busy    <= 1'b1;
      is_rd   <= start_rd;
      idx     <= '0;
      sr      <= frame_ld;
      mdio_oe <= 1'b1;
      if (start_rd) nv <= 1'b1;
    end else if (busy) begin
      if (rise && is_rd && idx >= DAT_IDX)
        rsh <= {rsh[DATA_BITS-2:0], mdio_i};
      if (fall) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          sr      <= '1;
          idx     <= '0;
          if (is_rd) begin
            rd_data <= rsh;
            nv      <= 1'b0;
          end
        end else begin
          idx <= idx + 1'b1;
          sr  <= {sr[FRAME_BITS-2:0], 1'b1};
          if (is_rd && (idx + 1'b1) == TA_IDX) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [2:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 busy,
  input  logic                 nv,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic                 srst,
  output logic [DIV_W-1:0]     div,
  output logic [FLD_W-1:0]     phy,
  output logic [FLD_W-1:0]     regn,
  output logic                 start_wr,
  output logic                 start_rd,
  output logic [DATA_BITS-1:0] start_data,
  output logic [BUS_W-1:0]     bus_rdata
);
  reg_sel_e             sel;
  logic                 locked;
  logic                 cmd_q;
  logic [DATA_BITS-1:0] ctrl_q;
  logic [BUS_W-1:0]     rd_mux;
  logic                 unused_wdata;

  assign sel          = reg_sel_e'(bus_addr);
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    locked     = busy | srst;
    start_wr   = bus_we && (sel == RA_CTRL) && !locked;
    start_rd   = bus_we && (sel == RA_CMD) && !locked
                 && bus_wdata[RDCMD_BIT] && !cmd_q;
    start_data = bus_wdata[DATA_BITS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      RA_CFG: begin
        rd_mux[SRST_BIT]    = srst;
        rd_mux[DIV_W-1:0]   = div;
      end
      RA_ADDR: begin
        rd_mux[PHY_LSB +: FLD_W] = phy;
        rd_mux[FLD_W-1:0]        = regn;
      end
      RA_CTRL: rd_mux[DATA_BITS-1:0] = ctrl_q;
      RA_CMD:  rd_mux[RDCMD_BIT]     = cmd_q;
      RA_STAT: rd_mux[DATA_BITS-1:0] = rd_data;
      RA_IND: begin
        rd_mux[BUSY_BIT] = busy;
        rd_mux[NV_BIT]   = nv;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst      <= 1'b0;
      div       <= DIV_W'(DIV_INIT);
      phy       <= '0;
      regn      <= '0;
      cmd_q     <= 1'b0;
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        case (sel)
          RA_CFG: begin
            srst <= bus_wdata[SRST_BIT];
            div  <= bus_wdata[DIV_W-1:0];
          end
          RA_ADDR: if (!locked) begin
            phy  <= bus_wdata[PHY_LSB +: FLD_W];
            regn <= bus_wdata[FLD_W-1:0];
          end
          RA_CTRL: if (!locked) ctrl_q <= bus_wdata[DATA_BITS-1:0];
          RA_CMD:  if (!locked) cmd_q  <= bus_wdata[RDCMD_BIT];
          default: ;
        endcase
      end
      if (bus_re) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic                 cfg_srst;
  logic [DIV_W-1:0]     cfg_div;
  logic [FLD_W-1:0]     phy_sel;
  logic [FLD_W-1:0]     regn_sel;
  logic                 st_wr;
  logic                 st_rd;
  logic [DATA_BITS-1:0] st_data;
  logic                 eng_busy;
  logic                 eng_rd;
  logic                 eng_nv;
  logic [DATA_BITS-1:0] rd_word;
  logic                 tick_rise;
  logic                 tick_fall;
  logic                 div_run;

  assign div_run = eng_busy && !cfg_srst;

  mdio_regs #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(eng_busy), .nv(eng_nv), .rd_data(rd_word),
    .srst(cfg_srst), .div(cfg_div), .phy(phy_sel), .regn(regn_sel),
    .start_wr(st_wr), .start_rd(st_rd), .start_data(st_data),
    .bus_rdata(bus_rdata)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(div_run), .div(cfg_div),
    .mdc(mdc), .rise_tick(tick_rise), .fall_tick(tick_fall)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .srst(cfg_srst),
    .start_wr(st_wr), .start_rd(st_rd),
    .phy(phy_sel), .regn(regn_sel), .wdata(st_data),
    .rise(tick_rise), .fall(tick_fall), .mdio_i(mdio_i),
    .busy(eng_busy), .is_rd(eng_rd), .nv(eng_nv), .rd_data(rd_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       is_rd,
  input logic       nv,
  input logic       srst,
  input logic       mdc,
  input logic       mdio_oe,
  input logic [9:0] addr_flds
);
  // R8: MDC rests low whenever no frame is active
  assert_idle_mdc_low_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R9: the line is only ever driven inside a frame
  assert_oe_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R7: a held soft reset keeps the engine idle with no pending result
  assert_srst_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (srst && $past(srst)) |-> (!busy && !nv && !mdc));

  // R5: a read that begins raises the result-pending flag
  assert_read_sets_nv_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && is_rd) |-> nv);

  // R10: address fields cannot change across an edge taken while active
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(addr_flds));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(eng_busy), .is_rd(eng_rd), .nv(eng_nv),
  .srst(cfg_srst), .mdc(mdc), .mdio_oe(mdio_oe),
  .addr_flds({phy_sel, regn_sel})
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_INIT   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  ba = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe;
  logic        mdi = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(ba),
    .bus_wdata(wd), .bus_rdata(rdata), .mdc(mdc), .mdio_o(mdo),
    .mdio_oe(moe), .mdio_i(mdi)
  );

  // ---------------- behavioural reference model ----------------
  int          m_div, m_deff, m_m, m_phy, m_reg;
  bit          m_srst, m_cmd, m_busy, m_rd, m_nv;
  logic [15:0] m_ctrl, m_stat;
  logic [63:0] m_frame;
  bit          phy_here = 1;
  logic [15:0] phy_val  = 16'h0;

  task automatic start_frame(input bit rd);
    m_busy  = 1; m_m = 0; m_rd = rd;
    m_deff  = (m_div == 0) ? 1 : m_div;
    if (rd) m_nv = 1;
    m_frame = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, 5'(m_phy), 5'(m_reg),
               2'b10, rd ? 16'h0 : m_ctrl};
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_div = DIV_INIT; m_deff = 1; m_m = 0; m_phy = 0; m_reg = 0;
      m_srst = 0; m_cmd = 0; m_busy = 0; m_rd = 0; m_nv = 0;
      m_ctrl = 0; m_stat = 0;
    end else begin
      bit lk;
      lk = m_busy || m_srst;
      if (m_srst) begin
        m_busy = 0; m_nv = 0;
      end else if (m_busy) begin
        m_m++;
        if (m_m == 128 * (m_deff + 1)) begin
          m_busy = 0;
          if (m_rd) begin
            m_stat = phy_here ? phy_val : 16'hFFFF;
            m_nv   = 0;
          end
        end
      end
      if (we) begin
        case (ba)
          3'd0: begin m_div = int'(wd[7:0]); m_srst = wd[31]; end
          3'd1: if (!lk) begin m_phy = int'(wd[12:8]); m_reg = int'(wd[4:0]); end
          3'd2: if (!lk) begin m_ctrl = wd[15:0]; start_frame(0); end
          3'd3: if (!lk) begin
            if (wd[0] && !m_cmd) start_frame(1);
            m_cmd = wd[0];
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_reg(input logic [2:0] a);
    case (a)
      3'd0: model_reg = {m_srst, 23'h0, 8'(m_div)};
      3'd1: model_reg = {19'h0, 5'(m_phy), 3'h0, 5'(m_reg)};
      3'd2: model_reg = {16'h0, m_ctrl};
      3'd3: model_reg = {31'h0, m_cmd};
      3'd4: model_reg = {16'h0, m_stat};
      3'd5: model_reg = {30'h0, m_nv, m_busy};
      default: model_reg = 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of the line outputs, and the PHY/pull-up model
  always @(negedge clk) begin
    if (!rst && !done) begin
      int hp, bi;
      bit e_mdc, e_oe;
      hp    = m_deff + 1;
      bi    = m_m / (2 * hp);
      e_mdc = m_busy ? ((m_m / hp) % 2 == 1) : 1'b0;
      e_oe  = m_busy && (!m_rd || bi < 46);
      check("R8 mdc", {31'h0, mdc}, {31'h0, e_mdc});
      check("R9 mdio_oe", {31'h0, moe}, {31'h0, e_oe});
      if (e_oe) check("R2 mdio_o", {31'h0, mdo}, {31'h0, m_frame[63 - bi]});
      if (m_busy && m_rd && bi >= 48 && phy_here) mdi = phy_val[15 - (bi - 48)];
      else mdi = 1'b1;
    end
  end

  // ---------------- host-side tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; ba = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk); re = 1; ba = a; exp = model_reg(a);
    @(negedge clk); re = 0;
    check(tag, rdata, exp);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11: reset state of every register
    for (int a = 0; a < 6; a++) rd_chk(3'(a), "R11 reset value");

    // R1: address register layout
    wr(3'd1, 32'hFFFF_E0FF & 32'h0000_0A03 | 32'h0000_0500);
    rd_chk(3'd1, "R1 address fields");
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, "R1 address other bits zero");
    wr(3'd1, {19'h0, 5'd5, 3'h0, 5'd3});

    // R2/R4: write frame at default divider, busy flag polled mid-frame
    wr(3'd2, 32'h0000_A5C3);
    rd_chk(3'd5, "R4 busy during write");
    wait_idle();
    rd_chk(3'd5, "R4 busy cleared after write");
    rd_chk(3'd2, "R2 write data stored");

    // R8: divider 0 clamps to 1; another data pattern
    wr(3'd0, 32'h0);
    rd_chk(3'd0, "R8 divider written as zero");
    wr(3'd2, 32'h0000_5A3C);
    wait_idle();

    // R3/R5/R6/R9: read with a PHY present
    phy_here = 1; phy_val = 16'h1234;
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h1);
    rd_chk(3'd5, "R5 pending set during read");
    wait_idle();
    rd_chk(3'd5, "R5 pending cleared after read");
    rd_chk(3'd4, "R6 read result");

    // R3: rewriting 1 must not relaunch
    wr(3'd3, 32'h1);
    repeat (10) @(negedge clk);
    rd_chk(3'd5, "R3 no relaunch on repeated 1");

    // R6: absent PHY gives all ones
    phy_here = 0;
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h1);
    wait_idle();
    rd_chk(3'd4, "R6 absent phy");

    // R10: writes during a frame are dropped; divider 3
    phy_here = 1; phy_val = 16'hBEEF;
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_0F0F);
    wr(3'd1, {19'h0, 5'd17, 3'h0, 5'd9});
    wr(3'd2, 32'h0000_1111);
    wr(3'd3, 32'h0);
    wait_idle();
    rd_chk(3'd1, "R10 address kept");
    rd_chk(3'd2, "R10 write data kept");
    rd_chk(3'd3, "R10 command kept");

    // R10 boundary: write on the last active edge dropped, next accepted
    wr(3'd2, 32'h0000_00FF);
    while (!(m_busy && m_m == 128 * (m_deff + 1) - 1)) @(negedge clk);
    we = 1; ba = 3'd2; wd = 32'h0000_C001;
    @(negedge clk);
    wd = 32'h0000_7E57;
    @(negedge clk);
    we = 0;
    rd_chk(3'd5, "R10 second attempt launched");
    wait_idle();
    rd_chk(3'd2, "R10 boundary data");

    // R7: soft reset during a read
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h1);
    repeat (40) @(negedge clk);
    wr(3'd0, 32'h8000_0003);
    repeat (3) @(negedge clk);
    rd_chk(3'd5, "R7 idle under soft reset");
    rd_chk(3'd0, "R7 setup readback");
    wr(3'd3, 32'h0);
    rd_chk(3'd3, "R7 command write dropped");
    wr(3'd0, 32'd1);
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h1);
    wait_idle();
    rd_chk(3'd4, "R6 read after soft reset");

    done = 1;
    summary();
    $finish;
  end
endmodule